// File: doc/BRIEF.md
# Multi-LED Network Event Controller

This block drives five status LED pins from the port's link and traffic indications. Each LED owns a 5-bit event selector, so it can show a speed, a speed group, duplex, collisions or traffic. Traffic can be shown as blinking on its own, or as blinking over a steady link indication. An LED can also be forced on or forced off. Software programs the selectors, one shared blink rate and a per-LED active-low bit through a simple write port. All of these reset to a quiet state.

Transmit, receive and collision indications arrive as single-cycle pulses. Each kind of pulse restarts its own hold window, counted in prescaled ticks, and the LEDs that follow that kind of traffic blink for as long as the window stays open. All LEDs blink from one shared phase, so they stay in step with each other. The block does not negotiate speed. It only decodes the speed code that it is given.

Top module: `led_event_ctrl`

## Requirements
- R1: A write decodes only four kinds of address. LED n takes its selector from data bits 15:11 at address 0x1800 + 0x10·n. The shared blink field is data bits 7:0 at address 0x1881. The polarity bit for LED n is data bit 8+n at address 0x000E. A write to any other address changes no pin.
- R2: After a synchronous active-low reset, every selector is 21 (forced off), every polarity bit is clear, the blink field is 0 and all pins are low.
- R3: The speed code is decoded only while link_up is high. The codes are 0x00 = 10M, 0x20 = 100M, 0x10 = 1G, 0x09 = 2.5G, 0x05 = 5G and 0x03 = 10G, and any other code matches no speed. Selectors 0 to 5 light the LED for 10M, 100M, 1G, 2.5G, 5G and 10G in that order. Selector 6 lights it for the 10M/100M/1G group and selector 7 for the 2.5G/5G/10G group.
- R4: Selector 8 lights the LED while linked at full duplex. Selector 9 lights it while the collision hold window is open. Selector 13 lights it while linked. Selector 19 lights it while linked at full duplex and makes it follow the blink phase while the collision window is open.
- R5: A pulse reloads its hold counter to HOLD_TICKS. The counter drops by one on each tick while it is nonzero, and the activity it represents counts as present while the counter is nonzero. There are four such counters: transmit, receive, any traffic (transmit or receive) and collision.
- R6: A tick occurs once every TICK_DIV clock cycles. The shared blink phase inverts after blink-field + 1 ticks.
- R7: Selectors 10, 11 and 12 show the blink phase while transmit, receive or any-traffic activity is present, and are off otherwise.
- R8: The compound selectors stay on and show the blink phase while their activity is present. Selector 14 does this for link with any traffic, 15 for link with receive traffic, 16 for the low speed group with any traffic, and 17 for the high speed group with any traffic. Selector 18 is on for the high group and shows the blink phase for the low group.
- R9: Selector 20 forces the LED on. Selector 21 and the undefined selectors 22 to 31 force it off.
- R10: A set polarity bit inverts the level of that LED's pin.
- R11: Each pin is registered. A change on any input or in the stored state appears on the pin exactly one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 16 | Register write data |
| link_up | input | 1 | Link established |
| speed_code | input | 8 | Resolved speed code |
| full_duplex | input | 1 | Link is full duplex |
| collision | input | 1 | Collision event pulse |
| tx_pulse | input | 1 | Transmit activity pulse |
| rx_pulse | input | 1 | Receive activity pulse |
| led_pin | output | 5 | LED pins, one per LED |

## Verification
Every internal state reaches a pin within one edge of the cycle it changes, as long as some LED selects an event that depends on that state. A wrong tick count or blink counter shows as a pin edge that comes early or late on a blinking LED. A hold counter that reloads or expires at the wrong time shows as a blink that stops early or runs too long. A wrong selector or polarity bit shows as a wrong steady level on the very next edge. The bench sweeps selectors, speeds and pulse patterns while a behavioural model predicts all five pins on every cycle, so any of these faults shows up within one blink period.

// File: rtl/led_evt_pkg.sv
// Shared types for the LED event controller.
// Assumes: 5-bit event selectors and 8-bit speed codes.
package led_evt_pkg;

    typedef enum logic [4:0] {
        EV_L10       = 5'd0,
        EV_L100      = 5'd1,
        EV_L1G       = 5'd2,
        EV_L2G5      = 5'd3,
        EV_L5G       = 5'd4,
        EV_L10G      = 5'd5,
        EV_LOWGRP    = 5'd6,
        EV_HIGRP     = 5'd7,
        EV_FDX       = 5'd8,
        EV_COL       = 5'd9,
        EV_BTX       = 5'd10,
        EV_BRX       = 5'd11,
        EV_BACT      = 5'd12,
        EV_LINK      = 5'd13,
        EV_LINK_BACT = 5'd14,
        EV_LINK_BRX  = 5'd15,
        EV_LOW_BACT  = 5'd16,
        EV_HI_BACT   = 5'd17,
        EV_HI_BLOW   = 5'd18,
        EV_FDX_BCOL  = 5'd19,
        EV_FORCE_ON  = 5'd20,
        EV_FORCE_OFF = 5'd21
    } led_evt_e;

    // One flag per decoded speed, already qualified by link
    typedef struct packed {
        logic l10;
        logic l100;
        logic l1g;
        logic l2g5;
        logic l5g;
        logic l10g;
    } spd_t;

    // Held activity flags
    typedef struct packed {
        logic col;
        logic any;
        logic rx;
        logic tx;
    } act_t;

    // Decode the speed code into one-hot speed flags, gated by link
    function automatic spd_t decode_speed(input logic [7:0] code, input logic link);
        spd_t s;
        s = '0;
        if (link) begin
            case (code)
                8'h00:   s.l10  = 1'b1;
                8'h20:   s.l100 = 1'b1;
                8'h10:   s.l1g  = 1'b1;
                8'h09:   s.l2g5 = 1'b1;
                8'h05:   s.l5g  = 1'b1;
                8'h03:   s.l10g = 1'b1;
                default: s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/led_cfg_regs.sv
// Write-only configuration bank: per-LED event selectors, shared blink
// field and per-LED polarity bits. Assumes single-cycle write strobes;
// writes to undecoded addresses are dropped.
module led_cfg_regs
    import led_evt_pkg::*;
#(
    parameter int NUM_LEDS   = 5,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int EVT_W      = 5,
    parameter int EVT_LSB    = 11,
    parameter int BLINK_W    = 8,
    parameter int POL_LSB    = 8,
    parameter int LED_BASE   = 'h1800,
    parameter int LED_STRIDE = 'h10,
    parameter int BLINK_ADDR = 'h1881,
    parameter int POL_ADDR   = 'h000E
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_LEDS-1:0][EVT_W-1:0] evt_o,
    output logic [NUM_LEDS-1:0]            pol_o,
    output logic [BLINK_W-1:0]             blink_o
);
    localparam logic [ADDR_W-1:0] BLINK_A = ADDR_W'(BLINK_ADDR);
    localparam logic [ADDR_W-1:0] POL_A   = ADDR_W'(POL_ADDR);

    logic unused_bits;
    assign unused_bits = &{1'b0, wr_data};

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(LED_BASE + i * LED_STRIDE);

        // Hold LED i's event selector
        always_ff @(posedge clk) begin
            if (!rst_n)
                evt_o[i] <= EVT_W'(EV_FORCE_OFF);
            else if (wr_en && wr_addr == MY_A)
                evt_o[i] <= wr_data[EVT_LSB +: EVT_W];
        end

        // Hold LED i's polarity bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                pol_o[i] <= 1'b0;
            else if (wr_en && wr_addr == POL_A)
                pol_o[i] <= wr_data[POL_LSB + i];
        end

        assert_cfg_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == MY_A) |=> evt_o[i] == $past(wr_data[EVT_LSB +: EVT_W]));
    end

    // Hold the shared blink field
    always_ff @(posedge clk) begin
        if (!rst_n)
            blink_o <= '0;
        else if (wr_en && wr_addr == BLINK_A)
            blink_o <= wr_data[BLINK_W-1:0];
    end

endmodule

// File: rtl/led_blink_gen.sv
// Tick prescaler and shared blink phase. Assumes TICK_DIV >= 1; the phase
// inverts after blink_cfg + 1 ticks and a shortened field takes effect
// at the next tick.
module led_blink_gen #(
    parameter int TICK_DIV = 1000,
    parameter int BLINK_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BLINK_W-1:0] blink_cfg,
    output logic               tick,
    output logic               phase
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0]   pre_q;
    logic [BLINK_W-1:0] ph_cnt_q;

    assign tick = (pre_q == PRE_LAST);

    // Free-running prescaler
    always_ff @(posedge clk) begin
        if (!rst_n || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // Count ticks and invert the phase at the end of each half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_cnt_q <= '0;
            phase    <= 1'b0;
        end else if (tick) begin
            if (ph_cnt_q >= blink_cfg) begin
                ph_cnt_q <= '0;
                phase    <= ~phase;
            end else begin
                ph_cnt_q <= ph_cnt_q + 1'b1;
            end
        end
    end

    assert_phase_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));

    if (TICK_DIV > 1) begin : g_tick_chk
        assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end

endmodule

// File: rtl/led_activity_timer.sv
// Hold window for one kind of activity pulse: reload on pulse, count down
// on tick, report activity while nonzero. Assumes HOLD_TICKS >= 1.
module led_activity_timer #(
    parameter int HOLD_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pulse,
    output logic active
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    logic [HW-1:0] cnt_q;

    assign active = (cnt_q != '0);

    // Reload on pulse, drain one per tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (pulse)
            cnt_q <= HW'(HOLD_TICKS);
        else if (tick && active)
            cnt_q <= cnt_q - 1'b1;
    end

    assert_hold_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> active);

    assert_idle_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && !active) |=> !active);

endmodule

// File: rtl/led_event_mux.sv
// Per-LED event selection and polarity, registered to the pin.
// Assumes speed flags are already link-qualified and activity is held.
module led_event_mux
    import led_evt_pkg::*;
#(
    parameter int EVT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt,
    input  logic             active_low,
    input  logic             link,
    input  spd_t             spd,
    input  logic             fdx,
    input  act_t             act,
    input  logic             phase,
    output logic             pin
);
    logic lo_grp, hi_grp, on_c;

    assign lo_grp = spd.l10 | spd.l100 | spd.l1g;
    assign hi_grp = spd.l2g5 | spd.l5g | spd.l10g;

    // Resolve the logical LED state for the selected event
    always_comb begin
        case (evt)
            EV_L10:       on_c = spd.l10;
            EV_L100:      on_c = spd.l100;
            EV_L1G:       on_c = spd.l1g;
            EV_L2G5:      on_c = spd.l2g5;
            EV_L5G:       on_c = spd.l5g;
            EV_L10G:      on_c = spd.l10g;
            EV_LOWGRP:    on_c = lo_grp;
            EV_HIGRP:     on_c = hi_grp;
            EV_FDX:       on_c = link & fdx;
            EV_COL:       on_c = act.col;
            EV_BTX:       on_c = act.tx & phase;
            EV_BRX:       on_c = act.rx & phase;
            EV_BACT:      on_c = act.any & phase;
            EV_LINK:      on_c = link;
            EV_LINK_BACT: on_c = link & (~act.any | phase);
            EV_LINK_BRX:  on_c = link & (~act.rx | phase);
            EV_LOW_BACT:  on_c = lo_grp & (~act.any | phase);
            EV_HI_BACT:   on_c = hi_grp & (~act.any | phase);
            EV_HI_BLOW:   on_c = hi_grp | (lo_grp & phase);
            EV_FDX_BCOL:  on_c = link & fdx & (~act.col | phase);
            EV_FORCE_ON:  on_c = 1'b1;
            default:      on_c = 1'b0;
        endcase
    end

    // Apply polarity and register to the pin
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin <= 1'b0;
        else
            pin <= on_c ^ active_low;
    end

    assert_forced_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt >= EVT_W'(EV_FORCE_OFF)) |=> pin == $past(active_low));

    assert_forced_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EVT_W'(EV_FORCE_ON)) |=> pin == !$past(active_low));

endmodule

// File: rtl/led_event_ctrl.sv
// Top of the LED event controller: configuration bank, blink generator,
// four activity hold timers and one event mux per LED.
// Assumes activity inputs are single-cycle pulses synchronous to clk.
module led_event_ctrl
    import led_evt_pkg::*;
#(
    parameter int NUM_LEDS   = 5,
    parameter int TICK_DIV   = 1000,
    parameter int HOLD_TICKS = 16,
    parameter int BLINK_W    = 8,
    parameter int EVT_W      = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [15:0]         wr_addr,
    input  logic [15:0]         wr_data,
    input  logic                link_up,
    input  logic [7:0]          speed_code,
    input  logic                full_duplex,
    input  logic                collision,
    input  logic                tx_pulse,
    input  logic                rx_pulse,
    output logic [NUM_LEDS-1:0] led_pin
);
    localparam int NUM_ACT = 4;

    logic [NUM_LEDS-1:0][EVT_W-1:0] evt;
    logic [NUM_LEDS-1:0]            pol;
    logic [BLINK_W-1:0]             blink_cfg;
    logic                           tick, phase;
    logic [NUM_ACT-1:0]             pulses, held;
    act_t                           act;
    spd_t                           spd;

    led_cfg_regs #(
        .NUM_LEDS(NUM_LEDS), .ADDR_W(16), .DATA_W(16), .EVT_W(EVT_W),
        .BLINK_W(BLINK_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_o(evt), .pol_o(pol), .blink_o(blink_cfg)
    );

    led_blink_gen #(.TICK_DIV(TICK_DIV), .BLINK_W(BLINK_W)) u_blink (
        .clk(clk), .rst_n(rst_n), .blink_cfg(blink_cfg),
        .tick(tick), .phase(phase)
    );

    assign pulses = {collision, tx_pulse | rx_pulse, rx_pulse, tx_pulse};

    for (genvar k = 0; k < NUM_ACT; k++) begin : g_act
        led_activity_timer #(.HOLD_TICKS(HOLD_TICKS)) u_tmr (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .pulse(pulses[k]), .active(held[k])
        );
    end

    assign act = act_t'(held);
    assign spd = decode_speed(speed_code, link_up);

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        led_event_mux #(.EVT_W(EVT_W)) u_mux (
            .clk(clk), .rst_n(rst_n), .evt(evt[i]), .active_low(pol[i]),
            .link(link_up), .spd(spd), .fdx(full_duplex), .act(act),
            .phase(phase), .pin(led_pin[i])
        );
    end

endmodule

// File: tb/tb_led_event_ctrl.sv
module tb_led_event_ctrl;
    localparam int TD   = 4;
    localparam int HOLD = 6;
    localparam int N    = 5;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_addr = '0, wr_data = '0;
    logic        link_up = 1'b0;
    logic [7:0]  speed_code = '0;
    logic        full_duplex = 1'b0, collision = 1'b0, tx_pulse = 1'b0, rx_pulse = 1'b0;
    logic [N-1:0] led_pin;

    always #5 clk = ~clk;

    led_event_ctrl #(.NUM_LEDS(N), .TICK_DIV(TD), .HOLD_TICKS(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .link_up(link_up), .speed_code(speed_code),
        .full_duplex(full_duplex), .collision(collision),
        .tx_pulse(tx_pulse), .rx_pulse(rx_pulse), .led_pin(led_pin)
    );

    int    checks = 0, errors = 0;
    string cur_tag = "R2";

    // Behavioural model state
    int m_pre = 0, m_ph = 0, m_phase = 0, m_blink = 0;
    int m_cnt [4];
    int m_evt [N];
    int m_pol [N];
    logic [N-1:0] exp_pins = '0;

    function automatic int speed_idx(input logic [7:0] c);
        case (c)
            8'h00: return 0;
            8'h20: return 1;
            8'h10: return 2;
            8'h09: return 3;
            8'h05: return 4;
            8'h03: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic bit model_on(input int code);
        int idx;
        bit lo, hi, tx, rx, an, co, ph, ln, fd;
        idx = link_up ? speed_idx(speed_code) : -1;
        lo = (idx >= 0 && idx <= 2);
        hi = (idx >= 3);
        tx = m_cnt[0] > 0; rx = m_cnt[1] > 0; an = m_cnt[2] > 0; co = m_cnt[3] > 0;
        ph = m_phase != 0; ln = link_up; fd = full_duplex;
        case (code)
            0, 1, 2, 3, 4, 5: return idx == code;
            6:  return lo;
            7:  return hi;
            8:  return ln && fd;
            9:  return co;
            10: return tx && ph;
            11: return rx && ph;
            12: return an && ph;
            13: return ln;
            14: return ln && (!an || ph);
            15: return ln && (!rx || ph);
            16: return lo && (!an || ph);
            17: return hi && (!an || ph);
            18: return hi || (lo && ph);
            19: return ln && fd && (!co || ph);
            20: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Advance the model one clock edge
    always @(posedge clk) begin
        bit tk;
        bit p [4];
        if (!rst_n) begin
            m_pre = 0; m_ph = 0; m_phase = 0; m_blink = 0;
            for (int k = 0; k < 4; k++) m_cnt[k] = 0;
            for (int i = 0; i < N; i++) begin m_evt[i] = 21; m_pol[i] = 0; end
            exp_pins = '0;
        end else begin
            for (int i = 0; i < N; i++) exp_pins[i] = model_on(m_evt[i]) ^ (m_pol[i] != 0);
            tk = (m_pre == TD - 1);
            m_pre = tk ? 0 : m_pre + 1;
            if (tk) begin
                if (m_ph >= m_blink) begin m_ph = 0; m_phase = 1 - m_phase; end
                else m_ph++;
            end
            p[0] = tx_pulse; p[1] = rx_pulse; p[2] = tx_pulse | rx_pulse; p[3] = collision;
            for (int k = 0; k < 4; k++) begin
                if (p[k]) m_cnt[k] = HOLD;
                else if (tk && m_cnt[k] > 0) m_cnt[k]--;
            end
            if (wr_en) begin
                for (int i = 0; i < N; i++)
                    if (int'(wr_addr) == 'h1800 + 'h10 * i) m_evt[i] = int'(wr_data[15:11]);
                if (wr_addr == 16'h1881) m_blink = int'(wr_data[7:0]);
                if (wr_addr == 16'h000E)
                    for (int i = 0; i < N; i++) m_pol[i] = int'(wr_data[8 + i]);
            end
        end
    end

    // Compare every cycle against the model
    always @(negedge clk) begin
        checks++;
        if (led_pin !== exp_pins) begin
            errors++;
            $display("FAIL %s model compare at %0t: got %b expected %b", cur_tag, $time, led_pin, exp_pins);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_pins(input logic [N-1:0] e, input string tag);
        checks++;
        if (led_pin !== e) begin
            errors++;
            $display("FAIL %s direct check: got %b expected %b", tag, led_pin, e);
        end
    endtask

    task automatic pulse_tx();  tx_pulse = 1'b1;  step(1); tx_pulse = 1'b0;  endtask
    task automatic pulse_rx();  rx_pulse = 1'b1;  step(1); rx_pulse = 1'b0;  endtask
    task automatic pulse_col(); collision = 1'b1; step(1); collision = 1'b0; endtask

    function automatic logic [15:0] sel(input int code);
        return 16'(code) << 11;
    endfunction

    initial begin
        logic [7:0] spds [7];
        spds = '{8'h00, 8'h20, 8'h10, 8'h09, 8'h05, 8'h03, 8'h44};
        step(3);
        rst_n = 1'b1;
        expect_pins(5'b00000, "R2");

        cur_tag = "R9";
        wr(16'h1800, sel(20));
        step(1);
        expect_pins(5'b00001, "R9");

        cur_tag = "R10";
        wr(16'h000E, 16'h0200);
        step(1);
        expect_pins(5'b00011, "R10");

        cur_tag = "R1";
        wr(16'h1811, sel(20));
        wr(16'h1882, 16'hFFFF);
        wr(16'h000F, 16'h1F00);
        step(2);
        expect_pins(5'b00011, "R1");

        cur_tag = "R11";
        wr(16'h1830, sel(13));
        step(1);
        link_up = 1'b1; speed_code = 8'h44;
        expect_pins(5'b00011, "R11");
        step(1);
        expect_pins(5'b01011, "R11");
        wr(16'h000E, 16'h0000);

        cur_tag = "R3";
        for (int c = 0; c < 8; c++) begin
            wr(16'h1820, sel(c));
            for (int s = 0; s < 7; s++) begin
                speed_code = spds[s];
                link_up = 1'b1; step(2);
                link_up = 1'b0; step(2);
            end
        end

        cur_tag = "R4";
        wr(16'h1881, 16'h0001);
        wr(16'h1800, sel(8)); wr(16'h1810, sel(9));
        wr(16'h1820, sel(13)); wr(16'h1830, sel(19));
        speed_code = 8'h10;
        for (int r = 0; r < 4; r++) begin
            link_up = r[0]; full_duplex = r[1];
            step(3);
            pulse_col();
            step(HOLD * TD + 8);
        end

        cur_tag = "R5";
        wr(16'h1840, sel(12));
        pulse_tx(); step(HOLD * TD + 6);
        pulse_rx(); step(5); pulse_rx(); step(HOLD * TD + 6);

        cur_tag = "R6";
        for (int b = 0; b < 3; b++) begin
            wr(16'h1881, 16'(b));
            wr(16'h1800, sel(20));
            for (int k = 0; k < 6; k++) begin pulse_tx(); step(3); end
        end

        cur_tag = "R7";
        wr(16'h1881, 16'h0000);
        wr(16'h1800, sel(10)); wr(16'h1810, sel(11)); wr(16'h1820, sel(12));
        for (int k = 0; k < 4; k++) begin pulse_tx(); step(7); end
        step(HOLD * TD);
        for (int k = 0; k < 4; k++) begin pulse_rx(); step(9); end
        step(HOLD * TD);

        cur_tag = "R8";
        wr(16'h1800, sel(14)); wr(16'h1810, sel(15)); wr(16'h1820, sel(16));
        wr(16'h1830, sel(17)); wr(16'h1840, sel(18));
        link_up = 1'b1;
        for (int s = 0; s < 7; s++) begin
            speed_code = spds[s];
            step(2);
            pulse_tx(); step(6); pulse_rx(); step(HOLD * TD + 4);
        end

        cur_tag = "R9";
        wr(16'h1800, sel(22)); wr(16'h1810, sel(31)); wr(16'h1820, sel(21));
        wr(16'h1830, sel(20)); wr(16'h1840, sel(27));
        pulse_tx(); step(4);
        expect_pins(5'b01000, "R9");

        cur_tag = "R10";
        wr(16'h000E, 16'h1F00);
        step(1);
        expect_pins(5'b10111, "R10");
        wr(16'h1800, sel(14));
        pulse_rx(); step(HOLD * TD + 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule